// File: doc/BRIEF.md
# Dual-Mode Wrapping Byte Address Counter

This block keeps the internal byte pointer of a 2048-byte serial memory. The memory is divided into eight blocks of 256 bytes, and each block is divided into 16-byte pages. A load strobe builds a fresh pointer. The three block-select bits come from the device-select byte and the eight low bits come from the address byte. An increment strobe then advances the pointer once for every byte that is transferred.

How far the pointer may travel depends on the mode input. In write mode only the four page-offset bits count, so a long burst circles inside its own page and overwrites the bytes it wrote earlier. In read mode all eleven bits count, so a long read runs through every block and comes back to zero after the last byte. When no load comes between accesses, the pointer always names the byte after the one last touched, whatever the previous mode was. A read that takes its address from the counter starts from that value.

Top module: `addr_wrap_ctr`

## Requirements
- R1: After reset the address output is 0.
- R2: When `loadEn` is 1 at a clock edge, the output after that edge is `{loadBlk, loadWord}` (block bits in [10:8], word bits in [7:0]). When `loadEn` is 0, the values on `loadBlk` and `loadWord` have no effect.
- R3: When `loadEn` and `incEn` are both 1, the load wins and no increment is applied in that cycle.
- R4: An increment with `modeRead`=0 (write) adds 1 modulo 16 to bits [3:0] and leaves bits [10:4] unchanged.
- R5: After sixteen write-mode increments the address is back at the value it had before them.
- R6: An increment with `modeRead`=1 (read) adds 1 to the whole 11-bit address, carrying across page and block boundaries.
- R7: A read-mode increment at address 2047 gives address 0.
- R8: With `loadEn` and `incEn` both 0, the address holds its value.
- R9: With no load in between, an increment continues from the current value, even when the previous increment was made in the other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Replace the address with the supplied fields |
| loadBlk | input | 3 | Block-select bits taken from the device-select byte |
| loadWord | input | 8 | Byte offset taken from the address byte |
| incEn | input | 1 | Advance after a byte has been accessed |
| modeRead | input | 1 | 1 = read (full wrap), 0 = write (page wrap) |
| addrOut | output | 11 | Current byte address |

## Verification
The assertions assume that `modeRead` is valid whenever `incEn` is 1. They also assume that the clock runs from reset onward, so that every `$past` value comes from a cycle that has already happened. The bench drives all inputs on the falling edge, keeps them steady across each rising edge, and holds `loadBlk` and `loadWord` at known values throughout. It also changes those fields while `loadEn` is 0, to show that they are ignored. A write burst is checked at the end of a page, and read increments are checked across a block boundary and across the top of memory.

// File: rtl/addr_wrap_pkg.sv
package addr_wrap_pkg;
  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic load;     // take new address fields
    logic incPage;  // advance inside the current page
    logic incFull;  // advance across the whole memory
  } ctrlStrb_t;
endpackage

// File: rtl/addr_wrap_ctrl.sv
module addr_wrap_ctrl
  import addr_wrap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadEn,
  input  logic      incEn,
  input  logic      modeRead,
  output ctrlStrb_t strb
);
  always_comb begin
    strb         = '0;
    strb.load    = loadEn;
    strb.incPage = incEn && !loadEn && !modeRead;
    strb.incFull = incEn && !loadEn && modeRead;
  end

  // R3: at most one action per cycle, and a load excludes both increments.
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.incPage, strb.incFull}));
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && incEn) |-> (strb.load && !strb.incPage && !strb.incFull));
endmodule

// File: rtl/addr_wrap_dp.sv
module addr_wrap_dp
  import addr_wrap_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] loadVal,
  output logic [ADDR_W-1:0] addrQ
);
  logic [ADDR_W-1:0] pageNext;
  logic [ADDR_W-1:0] fullNext;

  assign fullNext = addrQ + ADDR_W'(1);

  generate
    if (PAGE_W < ADDR_W) begin : g_split
      assign pageNext = {addrQ[ADDR_W-1:PAGE_W], addrQ[PAGE_W-1:0] + PAGE_W'(1)};
    end else begin : g_whole
      assign pageNext = fullNext;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             addrQ <= '0;
    else if (strb.load)    addrQ <= loadVal;
    else if (strb.incPage) addrQ <= pageNext;
    else if (strb.incFull) addrQ <= fullNext;
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (addrQ == '0));
  p_load_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (addrQ == $past(loadVal)));
  p_page_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPage |=> (addrQ[ADDR_W-1:PAGE_W] == $past(addrQ[ADDR_W-1:PAGE_W])));
  p_page_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPage |=> (addrQ[PAGE_W-1:0] == PAGE_W'($past(addrQ[PAGE_W-1:0]) + 1'b1)));
  p_full_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.incFull |=> (addrQ == ADDR_W'($past(addrQ) + 1'b1)));
  p_top_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incFull && (&addrQ)) |=> (addrQ == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.incPage && !strb.incFull) |=> $stable(addrQ));
endmodule

// File: rtl/addr_wrap_ctr.sv
module addr_wrap_ctr
  import addr_wrap_pkg::*;
#(
  parameter int BLK_W  = 3,
  parameter int WORD_W = 8,
  parameter int PAGE_W = 4,
  localparam int ADDR_W = BLK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [BLK_W-1:0]  loadBlk,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              incEn,
  input  logic              modeRead,
  output logic [ADDR_W-1:0] addrOut
);
  ctrlStrb_t strb;

  addr_wrap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .incEn    (incEn),
    .modeRead (modeRead),
    .strb     (strb)
  );

  addr_wrap_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadVal ({loadBlk, loadWord}),
    .addrQ   (addrOut)
  );
endmodule

// File: tb/addr_wrap_ctr_tb.sv
module addr_wrap_ctr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadBlk = '0;
  logic [7:0]  loadWord = '0;
  logic        incEn = 1'b0;
  logic        modeRead = 1'b0;
  logic [10:0] addrOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_wrap_ctr u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadBlk(loadBlk),
    .loadWord(loadWord), .incEn(incEn), .modeRead(modeRead), .addrOut(addrOut)
  );

  // {load, blk, word, inc, read, expected address after the edge}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 3'd5, 8'h3C, 1'b0, 1'b0, 11'h53C}, // R2 load
    {1'b0, 3'd5, 8'h3C, 1'b1, 1'b0, 11'h53D}, // R4
    {1'b0, 3'd5, 8'h3C, 1'b1, 1'b0, 11'h53E}, // R4
    {1'b0, 3'd5, 8'h3C, 1'b1, 1'b0, 11'h53F}, // R4
    {1'b0, 3'd5, 8'h3C, 1'b1, 1'b0, 11'h530}, // R4 page wrap
    {1'b0, 3'd1, 8'h77, 1'b0, 1'b0, 11'h530}, // R8 hold, R2 fields ignored
    {1'b0, 3'd5, 8'h3C, 1'b1, 1'b1, 11'h531}, // R9 read after write
    {1'b1, 3'd2, 8'hFF, 1'b1, 1'b1, 11'h2FF}, // R3 load wins
    {1'b0, 3'd2, 8'hFF, 1'b1, 1'b1, 11'h300}, // R6 block carry
    {1'b1, 3'd7, 8'hFE, 1'b0, 1'b1, 11'h7FE}, // R2
    {1'b0, 3'd7, 8'hFE, 1'b1, 1'b1, 11'h7FF}, // R6
    {1'b0, 3'd7, 8'hFE, 1'b1, 1'b1, 11'h000}, // R7 top wrap
    {1'b1, 3'd3, 8'h0F, 1'b1, 1'b0, 11'h30F}, // R3 load wins in write mode
    {1'b0, 3'd3, 8'h0F, 1'b1, 1'b0, 11'h300}, // R4 no carry out of page
    {1'b0, 3'd3, 8'h0F, 1'b1, 1'b0, 11'h301}, // R4
    {1'b0, 3'd6, 8'hAA, 1'b1, 1'b1, 11'h302}  // R9 write then read, R2 fields ignored
  };

  task automatic check(input logic [10:0] exp, input string req);
    checks++;
    if (addrOut !== exp) begin
      fails++;
      $display("FAIL %s: addrOut=%h expected=%h", req, addrOut, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] start;
    logic [10:0] expAddr;
    @(negedge clk);
    @(negedge clk);
    check(11'h000, "R1 reset value");
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: drive on the falling edge, sample just after the rising edge.
    for (int i = 0; i < NVEC; i++) begin
      {loadEn, loadBlk, loadWord, incEn, modeRead} = VEC[i][24:11];
      tick();
      check(VEC[i][10:0], $sformatf("R2/R3/R4/R6/R7/R8/R9 vector %0d", i));
      @(negedge clk);
    end

    // R5: a sixteen-byte write burst starting mid-page comes back to its start.
    loadEn = 1'b1; loadBlk = 3'd4; loadWord = 8'h9A; incEn = 1'b0; modeRead = 1'b0;
    tick(); @(negedge clk);
    start = 11'h49A;
    loadEn = 1'b0; incEn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick();
      expAddr = {start[10:4], 4'(start[3:0] + 4'(k + 1))};
      check(expAddr, "R4 write burst step");
      @(negedge clk);
    end
    check(start, "R5 burst back to start");

    // R6/R7: a full read sweep visits every address and rolls over to 0.
    loadEn = 1'b1; loadBlk = 3'd0; loadWord = 8'h00; incEn = 1'b0;
    tick(); @(negedge clk);
    loadEn = 1'b0; incEn = 1'b1; modeRead = 1'b1;
    for (int k = 1; k <= 2048; k++) begin
      tick();
      check(11'(k), "R6 read sweep");
      @(negedge clk);
    end
    check(11'h000, "R7 sweep ends at 0");

    // R1: reset mid-run while an increment is requested.
    loadEn = 1'b1; loadBlk = 3'd6; loadWord = 8'h55; incEn = 1'b0;
    tick(); @(negedge clk);
    rstN = 1'b0; loadEn = 1'b0; incEn = 1'b1;
    tick();
    check(11'h000, "R1 reset during activity");
    @(negedge clk);
    rstN = 1'b1; incEn = 1'b0;
    tick();
    check(11'h000, "R8 hold after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule